// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Target Port

This block is the receiving end of an 8-bit parallel configuration link. A host drives an active-low select and an active-low write strobe together with a byte bus, and all sampling takes place on the rising edge of the configuration clock. During loading, every accepted byte has its bit order corrected and appears for one cycle on an internal valid/data stream. A programmable length register decides when loading is complete.

Once loading is complete, the pins stay in service only if the persist input was set. In that case the host can keep writing, or it can read back bytes. Readback bytes come from an internal ready/valid source and are driven onto the bus. If the host lifts the write strobe in the middle of a load, the port latches an abort and refuses further traffic. A sticky flag records every read that finds the source empty.

Top module: `cfgport_slave`

## Requirements
- R1: A byte is accepted on a rising edge where `sel_n` and `wr_n` are both 0 and the port is loading or persisting. After that edge, `wr_valid` is 1 for exactly one cycle and carries the byte on `wr_byte`.
- R2: Either control may fall first. An edge with only one of the two low writes nothing. While loading with zero bytes accepted, `sel_n`=0 with `wr_n`=1 has no effect.
- R3: Bus bit i corresponds to byte bit 7-i in both directions. For example, bus value 0x01 is delivered as byte 0x80.
- R4: `done` rises on the edge that accepts byte number `load_len` and stays at 1 until reset. A `load_len` of 0 stands for 65536 bytes.
- R5: While loading with at least one byte accepted, an edge with `sel_n`=0 and `wr_n`=1 sets `abort`. The flag is sticky, and no byte is accepted afterwards until reset.
- R6: While `sel_n` is 1, all other port inputs are ignored. Toggling `wr_n` causes no abort and no write.
- R7: In persist mode, `sel_n`=0 with `wr_n`=1 raises `bus_oe` and `rd_ready` in the same cycle. At the next edge, the head of the source is consumed, and its bit-reversed value shows on `bus_out` from that edge onward.
- R8: `bus_oe` is 0 whenever the readback condition of R7 does not hold.
- R9: `persist_en` is sampled on the completing edge. If it is 0 there, the port goes quiet: no writes, no reads, no abort, and `bus_oe` stays at 0.
- R10: A read edge with `rd_valid`=0 puts 0xFF on `bus_out` and sets the sticky `underrun` flag.
- R11: Synchronous active-high `rst` returns the port to loading and clears the count, `done`, `abort`, `underrun`, `wr_valid` and `bus_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Port select, active low |
| wr_n | input | 1 | 0 = write, 1 = read |
| bus_in | input | 8 | Byte bus from the host |
| bus_out | output | 8 | Readback byte toward the host |
| bus_oe | output | 1 | Bus output enable |
| load_len | input | 16 | Bytes in a load (0 means 65536) |
| persist_en | input | 1 | Keep the port alive after loading |
| wr_valid | output | 1 | One-cycle pulse per accepted byte |
| wr_byte | output | 8 | Accepted byte, bit order corrected |
| rd_valid | input | 1 | Readback source has a byte |
| rd_byte | input | 8 | Readback source byte |
| rd_ready | output | 1 | Readback source byte is taken at the next edge |
| done | output | 1 | Load complete |
| abort | output | 1 | Load aborted |
| underrun | output | 1 | Read found the source empty |

## Verification
`bus_oe` and `rd_ready` are combinational, so the bench compares them in the low half of the clock, while the inputs that produce them are held steady. `wr_valid`, `wr_byte`, `bus_out`, `done`, `abort` and `underrun` each pass through exactly one register. For these, the model is advanced with the inputs that were present at the edge, and the comparison is made one nanosecond after that same rising edge, before any input changes. The readback source is a queue in the bench that is popped only in the model step, which keeps `rd_valid` aligned to the edge that consumes it.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = 16;

    typedef enum logic [1:0] {
        PH_LOAD  = 2'd0,
        PH_LIVE  = 2'd1,
        PH_QUIET = 2'd2,
        PH_HALT  = 2'd3
    } phase_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } beat_t;

    typedef struct packed {
        logic wr_fire;
        logic rd_fire;
        logic abort_hit;
    } strobe_t;

    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/cfgport_swap.sv
module cfgport_swap #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign dout[g] = din[W-1-g];
    end
endmodule

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
(
    input  logic    sel_n,
    input  logic    wr_n,
    input  phase_t  phase,
    input  logic    cnt_nz,
    output strobe_t stb
);
    logic picked;
    logic accepting;

    assign picked    = ~sel_n;
    assign accepting = (phase == PH_LOAD) || (phase == PH_LIVE);

    always_comb begin
        stb           = '0;
        stb.wr_fire   = picked && !wr_n && accepting;
        stb.rd_fire   = picked && wr_n && (phase == PH_LIVE);
        stb.abort_hit = picked && wr_n && (phase == PH_LOAD) && cnt_nz;
    end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int CW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_t       stb,
    input  logic [CW-1:0] load_len,
    input  logic          persist_en,
    output phase_t        phase,
    output logic          cnt_nz,
    output logic          done,
    output logic          abort
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          last_hit;

    assign cnt_nxt  = cnt + {{(CW-1){1'b0}}, 1'b1};
    assign last_hit = (cnt_nxt == load_len);
    assign cnt_nz   = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LOAD;
            cnt   <= '0;
            done  <= 1'b0;
            abort <= 1'b0;
        end else begin
            if (stb.wr_fire && phase == PH_LOAD) begin
                cnt <= cnt_nxt;
                if (last_hit) begin
                    done  <= 1'b1;
                    phase <= persist_en ? PH_LIVE : PH_QUIET;
                end
            end
            if (stb.abort_hit) begin
                abort <= 1'b1;
                phase <= PH_HALT;
            end
        end
    end
endmodule

// File: rtl/cfgport_wpath.sv
module cfgport_wpath
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [BYTE_W-1:0] bus_in,
    output beat_t             beat
);
    logic [BYTE_W-1:0] fixed;

    cfgport_swap #(.W(BYTE_W)) u_swap (.din(bus_in), .dout(fixed));

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= fire;
            if (fire) beat.data <= fixed;
        end
    end
endmodule

// File: rtl/cfgport_rpath.sv
module cfgport_rpath
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_byte,
    output logic [BYTE_W-1:0] bus_out,
    output logic              underrun
);
    logic [BYTE_W-1:0] fixed;

    cfgport_swap #(.W(BYTE_W)) u_swap (.din(src_byte), .dout(fixed));

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_out  <= '0;
            underrun <= 1'b0;
        end else if (fire) begin
            if (src_valid) begin
                bus_out <= fixed;
            end else begin
                bus_out  <= '1;
                underrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgport_slave.sv
module cfgport_slave
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              persist_en,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              rd_ready,
    output logic              done,
    output logic              abort,
    output logic              underrun
);
    phase_t  phase;
    strobe_t stb;
    logic    cnt_nz;
    beat_t   beat;

    cfgport_decode u_dec (
        .sel_n  (sel_n),
        .wr_n   (wr_n),
        .phase  (phase),
        .cnt_nz (cnt_nz),
        .stb    (stb)
    );

    cfgport_ctrl #(.CW(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .stb        (stb),
        .load_len   (load_len),
        .persist_en (persist_en),
        .phase      (phase),
        .cnt_nz     (cnt_nz),
        .done       (done),
        .abort      (abort)
    );

    cfgport_wpath u_wp (
        .clk    (clk),
        .rst    (rst),
        .fire   (stb.wr_fire),
        .bus_in (bus_in),
        .beat   (beat)
    );

    cfgport_rpath u_rp (
        .clk       (clk),
        .rst       (rst),
        .fire      (stb.rd_fire),
        .src_valid (rd_valid),
        .src_byte  (rd_byte),
        .bus_out   (bus_out),
        .underrun  (underrun)
    );

    assign wr_valid = beat.valid;
    assign wr_byte  = beat.data;
    assign bus_oe   = stb.rd_fire;
    assign rd_ready = stb.rd_fire;
endmodule

// File: rtl/cfgport_slave_chk.sv
module cfgport_slave_chk
    import cfgport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              wr_n,
    input logic [BYTE_W-1:0] bus_in,
    input logic [BYTE_W-1:0] bus_out,
    input logic              bus_oe,
    input logic [LEN_W-1:0]  load_len,
    input logic              persist_en,
    input logic              wr_valid,
    input logic [BYTE_W-1:0] wr_byte,
    input logic              rd_valid,
    input logic [BYTE_W-1:0] rd_byte,
    input logic              rd_ready,
    input logic              done,
    input logic              abort,
    input logic              underrun
);
    a_r8_oe_needs_read: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!sel_n && wr_n));

    a_r1_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n && !abort && !done) |=> wr_valid);

    a_r3_write_order: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wr_n && !abort && !done) |=> (wr_byte == flip_byte($past(bus_in))));

    a_r3_read_order: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && rd_valid) |=> (bus_out == flip_byte($past(rd_byte))));

    a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r5_abort_sticky: assert property (@(posedge clk) disable iff (rst)
        abort |=> abort);

    a_r5_no_write_after_abort: assert property (@(posedge clk) disable iff (rst)
        abort |=> !wr_valid);

    a_r6_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !abort) |=> !abort);

    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    a_r10_empty_read_ff: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !rd_valid) |=> (underrun && bus_out == '1));
endmodule

bind cfgport_slave cfgport_slave_chk u_chk (.*);

// File: tb/cfgport_slave_test.sv
module cfgport_slave_test;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic [15:0] load_len = 16'd4;
    logic       persist_en = 1'b0;
    logic       wr_valid;
    logic [7:0] wr_byte;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_byte = '0;
    logic       rd_ready;
    logic       done;
    logic       abort;
    logic       underrun;

    cfgport_slave uut (.*);

    always #(CLK_NS/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference: 0 loading, 1 persisting, 2 quiet, 3 aborted
    int       m_mode = 0;
    int       m_cnt = 0;
    bit       m_done = 0, m_abort = 0, m_under = 0, m_wv = 0;
    bit [7:0] m_wb = 0, m_bo = 0;
    byte unsigned src_q[$];

    function automatic bit [7:0] mirror(input bit [7:0] b);
        bit [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_src();
        rd_valid = (src_q.size() > 0);
        rd_byte  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    endtask

    task automatic model_edge();
        bit rdc, wrc;
        rdc = (m_mode == 1) && !sel_n && wr_n;
        wrc = (m_mode <= 1) && !sel_n && !wr_n;
        m_wv = 0;
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_done = 0; m_abort = 0; m_under = 0;
            m_wb = 0; m_bo = 0;
        end else begin
            if (wrc) begin
                m_wv = 1;
                m_wb = mirror(bus_in);
                if (m_mode == 0) begin
                    m_cnt++;
                    if ((m_cnt % 65536) == int'(load_len)) begin
                        m_done = 1;
                        m_mode = persist_en ? 1 : 2;
                    end
                end
            end else if (m_mode == 0 && !sel_n && wr_n && m_cnt > 0) begin
                m_abort = 1;
                m_mode = 3;
            end
            if (rdc) begin
                if (src_q.size() > 0) begin
                    m_bo = mirror(src_q.pop_front());
                end else begin
                    m_bo = 8'hFF;
                    m_under = 1;
                end
            end
        end
    endtask

    // one clock: combinational checks in the low phase, registered ones after the edge
    task automatic cyc();
        bit eo;
        @(negedge clk);
        eo = (m_mode == 1) && !sel_n && wr_n;
        chk("R8 bus_oe", bus_oe, eo);
        chk("R7 rd_ready", rd_ready, eo);
        @(posedge clk);
        #1;
        model_edge();
        chk("R1 wr_valid", wr_valid, m_wv);
        if (m_wv) chk("R1 wr_byte", wr_byte, m_wb);
        chk("R4 done", done, m_done);
        chk("R5 abort", abort, m_abort);
        chk("R10 underrun", underrun, m_under);
        chk("R7 bus_out", bus_out, m_bo);
        drive_src();
    endtask

    task automatic wr_byte_op(input bit [7:0] b);
        sel_n = 0; wr_n = 0; bus_in = b;
        cyc();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            sel_n = 1; cyc();
        end
    endtask

    task automatic do_reset();
        rst = 1; sel_n = 1; wr_n = 1;
        src_q.delete();
        drive_src();
        cyc(); cyc();
        rst = 0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        load_len = 16'd4; persist_en = 1;
        do_reset();
        idle(1);
        chk("R11 done after reset", done, 0);
        chk("R11 wr_valid after reset", wr_valid, 0);
        chk("R11 bus_out after reset", bus_out, 0);

        // R2: read condition before any byte, then strobe first, then select
        sel_n = 0; wr_n = 1; cyc();
        chk("R2 no abort at count zero", abort, 0);
        sel_n = 1; wr_n = 0; bus_in = 8'h01; cyc();
        chk("R2 strobe alone writes nothing", wr_valid, 0);
        sel_n = 0; cyc();
        chk("R2 both low writes", wr_valid, 1);
        chk("R3 bus 0x01 gives byte 0x80", wr_byte, 8'h80);

        // R6: deselected, wr_n toggling mid-load
        sel_n = 1; wr_n = 1; bus_in = 8'hAA; cyc();
        wr_n = 0; cyc();
        wr_n = 1; cyc();
        chk("R6 no abort while deselected", abort, 0);
        chk("R6 no write while deselected", wr_valid, 0);

        wr_byte_op(8'h0F);
        chk("R3 bus 0x0F gives 0xF0", wr_byte, 8'hF0);
        wr_byte_op(8'h3C);
        chk("R4 not done after 3", done, 0);
        wr_byte_op(8'hE1);
        chk("R4 done on byte 4", done, 1);
        wr_byte_op(8'h55);
        chk("R1 persist write accepted", wr_valid, 1);

        // R7 / R10 readback
        src_q.push_back(8'h12);
        src_q.push_back(8'hC3);
        drive_src();
        sel_n = 0; wr_n = 1;
        cyc();
        chk("R7 first readback byte", bus_out, 8'h48);
        cyc();
        chk("R7 second readback byte", bus_out, 8'hC3);
        cyc();
        chk("R10 empty read drives 0xFF", bus_out, 8'hFF);
        chk("R10 underrun set", underrun, 1);
        idle(2);
        chk("R10 underrun sticky", underrun, 1);

        // R9: no persist
        load_len = 16'd3; persist_en = 0;
        do_reset();
        chk("R11 underrun cleared", underrun, 0);
        wr_byte_op(8'h80);
        wr_byte_op(8'h40);
        wr_byte_op(8'h20);
        chk("R4 done at three", done, 1);
        wr_byte_op(8'h11);
        chk("R9 write ignored when quiet", wr_valid, 0);
        src_q.push_back(8'h77); drive_src();
        sel_n = 0; wr_n = 1; cyc();
        chk("R9 no read when quiet", bus_oe, 0);
        chk("R9 no abort when quiet", abort, 0);
        idle(1);

        // R5 abort
        load_len = 16'd5; persist_en = 1;
        do_reset();
        wr_byte_op(8'h01);
        wr_byte_op(8'h02);
        sel_n = 0; wr_n = 1; cyc();
        chk("R5 abort raised", abort, 1);
        wr_byte_op(8'h03);
        chk("R5 write refused after abort", wr_valid, 0);
        wr_byte_op(8'h04);
        wr_byte_op(8'h05);
        chk("R5 no done after abort", done, 0);
        idle(2);
        do_reset();
        chk("R11 abort cleared", abort, 0);
        idle(1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule